// File: doc/BRIEF.md
# Fractional-N Divide Controller

This block sets the division ratio of a PLL feedback path so that, averaged over many reference periods, the loop divides by INT + FRAC/MOD. It runs on the RF clock that comes into the divider. The dual-modulus prescaler (divide by P or P+1) is modelled as an internal counter that produces a clock-enable tick. A swallow pair of counters, B (main) and A (swallow), runs on those ticks. During each division the prescaler uses P+1 for A ticks and P for the remaining B−A ticks, so that one division lasts P·B + A RF cycles. At the end of each division the block emits a one-cycle feedback pulse towards the phase detector.

A third-order multi-stage noise-shaping modulator makes the fractional part. It has three cascaded first-order accumulators, and each of them wraps at the programmable modulus, not at a power of two. The modulator advances once per division. Its offset, which lies between −3 and +4, is added to INT to give the next division's N. That N is clamped to a floor that keeps A ≤ B, split into B and A, and loaded when the current division completes. A zero fraction bypasses the modulator completely. A synchronous counter-reset input restarts every counter and the modulator.

Top module: `fracn_div_ctrl`

## Requirements
- R1: While `rst_i` or `cnt_rst_i` is 1, `fb_o` stays 0. After release, the first pulse arrives exactly P RF cycles later, because the counters restart with B=1, A=0.
- R2: `fb_o` is high for exactly one cycle per division. The second interval after release equals the clamped INT, because the modulator starts from zero.
- R3: With an effective fraction of 0, every interval equals max(INT, P·P−P) exactly.
- R4: In steady state, any 6·MOD consecutive intervals sum to exactly 6·(INT·MOD + FRAC), which is an average of INT + FRAC/MOD per division.
- R5: With a non-zero fraction, each interval lies in [INT−3, INT+4].
- R6: A FRAC greater than or equal to MOD is treated as MOD−1.
- R7: A MOD below 2 disables the fraction, so N = INT.
- R8: N never goes below P·P−P, which is 12 for P=4 and 56 for P=8.
- R9: `psel_i`=0 selects P=4 and `psel_i`=1 selects P=8. The total interval is N for either choice.
- R10: Each division loads B = N div P and A = N mod P, with P a power of two. A ≤ B always holds, and a division lasts P·B + A cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RF clock into the divider |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_rst_i | input | 1 | Counter reset: holds the divider and the modulator cleared |
| psel_i | input | 1 | Prescaler select: 0 → P=4, 1 → P=8 |
| int_i | input | 9 | Integer part of N |
| frac_i | input | 12 | Fraction numerator |
| mod_i | input | 12 | Fraction modulus |
| fb_o | output | 1 | One-cycle pulse per completed division |

## Verification
The assertions check properties that must hold in every cycle. These are: no feedback pulse while counter reset is held, single-cycle pulses, A ≤ B at every load, a prescaler count that stays bounded, and a modulator offset inside −3..+4. The exact arithmetic of the divider can only be shown by the bench scenarios. These cover interval lengths, the clamp floor, the handling of FRAC ≥ MOD and MOD < 2, and the exact window sum over 6·MOD divisions, each measured by counting RF cycles between pulses.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  typedef enum logic {PRE_SMALL = 1'b0, PRE_LARGE = 1'b1} pre_sel_e;
  localparam int MASH_ORDER = 3;
  localparam int OFF_W      = 4;
endpackage

// File: rtl/fn_mash.sv
module fn_mash
  import fnd_pkg::*;
#(
  parameter int FR_W = 12
) (
  input  logic                    clk_i,
  input  logic                    clr_i,
  input  logic                    step_i,
  input  logic [FR_W-1:0]         frac_i,
  input  logic [FR_W-1:0]         mod_i,
  output logic signed [OFF_W-1:0] off_o
);
  logic                  frac_zero;
  logic                  step_en;
  logic [FR_W-1:0]       acc_d [MASH_ORDER];
  logic [MASH_ORDER-1:0] cy_d;
  logic [MASH_ORDER-1:0] cy_v;
  logic                  c2z_q, c3z_q, c3zz_q;
  int                    yi;

  assign frac_zero = (frac_i == '0);
  assign step_en   = step_i & ~frac_zero;

  genvar s;
  generate
    for (s = 0; s < MASH_ORDER; s++) begin : g_stage
      logic [FR_W-1:0] in_w;
      logic [FR_W-1:0] acc_q;
      logic [FR_W-1:0] nx_w;
      logic [FR_W:0]   sum_w;
      logic            cy_w;
      logic            cy_q;
      if (s == 0) begin : g_first
        assign in_w = frac_i;
      end else begin : g_next
        assign in_w = acc_d[s-1];
      end
      always_comb begin
        sum_w = {1'b0, acc_q} + {1'b0, in_w};
        cy_w  = (sum_w >= {1'b0, mod_i});
        nx_w  = cy_w ? FR_W'(sum_w - {1'b0, mod_i}) : sum_w[FR_W-1:0];
      end
      always_ff @(posedge clk_i) begin
        if (clr_i) begin
          acc_q <= '0;
          cy_q  <= 1'b0;
        end else if (step_en) begin
          acc_q <= nx_w;
          cy_q  <= cy_w;
        end
      end
      assign acc_d[s] = nx_w;
      assign cy_d[s]  = cy_w;
      assign cy_v[s]  = cy_q;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      c2z_q  <= 1'b0;
      c3z_q  <= 1'b0;
      c3zz_q <= 1'b0;
    end else if (step_en) begin
      c2z_q  <= cy_v[1];
      c3z_q  <= cy_v[2];
      c3zz_q <= c3z_q;
    end
  end

  always_comb begin
    yi = int'(cy_v[0]) + int'(cy_v[1]) - int'(c2z_q)
       + int'(cy_v[2]) - 2 * int'(c3z_q) + int'(c3zz_q);
    off_o = frac_zero ? '0 : OFF_W'(yi);
  end

  logic unused_cy;
  assign unused_cy = ^cy_d;

  assert_offset_range_R5: assert property (@(posedge clk_i) disable iff (clr_i)
    (off_o >= -4'sd3) && (off_o <= 4'sd4));
endmodule

// File: rtl/fn_swallow.sv
module fn_swallow
  import fnd_pkg::*;
#(
  parameter int B_W  = 9,
  parameter int A_W  = 3,
  parameter int P_LO = 4,
  parameter int P_HI = 8
) (
  input  logic           clk_i,
  input  logic           clr_i,
  input  pre_sel_e       psel_i,
  input  logic [B_W-1:0] b_load_i,
  input  logic [A_W-1:0] a_load_i,
  output logic           done_o,
  output logic           fb_o
);
  localparam int PC_W = $clog2(P_HI + 2);

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] last_w;
  logic [B_W-1:0]  b_rem_q;
  logic [A_W-1:0]  a_rem_q;
  logic            tick_w;
  logic            fb_q;

  always_comb begin
    last_w = (psel_i == PRE_LARGE) ? PC_W'(P_HI - 1) : PC_W'(P_LO - 1);
    if (a_rem_q != '0) last_w = last_w + 1'b1;
    tick_w = (pcnt_q == last_w);
    done_o = tick_w && (b_rem_q == B_W'(1));
  end

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      pcnt_q  <= '0;
      b_rem_q <= B_W'(1);
      a_rem_q <= '0;
      fb_q    <= 1'b0;
    end else begin
      fb_q <= done_o;
      if (tick_w) begin
        pcnt_q <= '0;
        if (done_o) begin
          b_rem_q <= b_load_i;
          a_rem_q <= a_load_i;
        end else begin
          b_rem_q <= b_rem_q - 1'b1;
          if (a_rem_q != '0) a_rem_q <= a_rem_q - 1'b1;
        end
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign fb_o = fb_q;

  assert_fb_single_R2: assert property (@(posedge clk_i) disable iff (clr_i)
    fb_o |=> !fb_o);
  assert_a_le_b_R10: assert property (@(posedge clk_i) disable iff (clr_i)
    done_o |-> (B_W'(a_load_i) <= b_load_i));
  assert_pcnt_range_R9: assert property (@(posedge clk_i) disable iff (clr_i)
    pcnt_q <= PC_W'(P_HI));
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fnd_pkg::*;
#(
  parameter int INT_W = 9,
  parameter int FR_W  = 12,
  parameter int B_W   = 9,
  parameter int A_W   = 3,
  parameter int P_LO  = 4,
  parameter int P_HI  = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cnt_rst_i,
  input  logic             psel_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [FR_W-1:0]  frac_i,
  input  logic [FR_W-1:0]  mod_i,
  output logic             fb_o
);
  localparam int N_W   = INT_W + 1;
  localparam int NR_W  = N_W + 2;
  localparam int SH_LO = $clog2(P_LO);
  localparam int SH_HI = $clog2(P_HI);
  localparam int MIN_LO = P_LO * P_LO - P_LO;
  localparam int MIN_HI = P_HI * P_HI - P_HI;

  logic                    clr;
  pre_sel_e                psel;
  logic [FR_W-1:0]         frac_eff;
  logic signed [OFF_W-1:0] off;
  logic signed [NR_W-1:0]  int_s, off_s, n_raw, nmin_s;
  logic [N_W-1:0]          n_load;
  logic [B_W-1:0]          b_load;
  logic [A_W-1:0]          a_load;
  logic                    done;

  assign clr  = rst_i | cnt_rst_i;
  assign psel = pre_sel_e'(psel_i);

  always_comb begin
    if (mod_i < FR_W'(2))      frac_eff = '0;
    else if (frac_i >= mod_i)  frac_eff = mod_i - 1'b1;
    else                       frac_eff = frac_i;
  end

  fn_mash #(.FR_W(FR_W)) u_mash (
    .clk_i  (clk_i),
    .clr_i  (clr),
    .step_i (done),
    .frac_i (frac_eff),
    .mod_i  (mod_i),
    .off_o  (off)
  );

  always_comb begin
    int_s  = NR_W'(int_i);
    off_s  = NR_W'(off);
    n_raw  = int_s + off_s;
    nmin_s = (psel == PRE_LARGE) ? NR_W'(MIN_HI) : NR_W'(MIN_LO);
    n_load = (n_raw < nmin_s) ? N_W'(nmin_s) : N_W'(n_raw);
    if (psel == PRE_LARGE) begin
      b_load = B_W'(n_load >> SH_HI);
      a_load = A_W'(n_load & N_W'(P_HI - 1));
    end else begin
      b_load = B_W'(n_load >> SH_LO);
      a_load = A_W'(n_load & N_W'(P_LO - 1));
    end
  end

  fn_swallow #(.B_W(B_W), .A_W(A_W), .P_LO(P_LO), .P_HI(P_HI)) u_swallow (
    .clk_i    (clk_i),
    .clr_i    (clr),
    .psel_i   (psel),
    .b_load_i (b_load),
    .a_load_i (a_load),
    .done_o   (done),
    .fb_o     (fb_o)
  );

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_rst_i |=> !fb_o);
endmodule

// File: tb/fracn_div_ctrl_tb.sv
module fracn_div_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {int[9], frac[12], mod[12], psel[1]}
  localparam logic [33:0] VEC [NVEC] = '{
    {9'd20,  12'd0,  12'd5,  1'b0},
    {9'd20,  12'd1,  12'd5,  1'b0},
    {9'd20,  12'd3,  12'd7,  1'b0},
    {9'd60,  12'd11, 12'd13, 1'b1},
    {9'd33,  12'd50, 12'd97, 1'b0},
    {9'd70,  12'd9,  12'd5,  1'b1},
    {9'd25,  12'd3,  12'd1,  1'b0},
    {9'd10,  12'd0,  12'd5,  1'b0},
    {9'd50,  12'd0,  12'd5,  1'b1},
    {9'd500, 12'd2,  12'd3,  1'b1},
    {9'd40,  12'd12, 12'd13, 1'b0},
    {9'd100, 12'd0,  12'd9,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_rst = 1'b0;
  logic        psel = 1'b0;
  logic [8:0]  int_v = 9'd20;
  logic [11:0] frac_v = '0;
  logic [11:0] mod_v = 12'd5;
  logic        fb;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_div_ctrl u_dut (
    .clk_i(clk), .rst_i(rst), .cnt_rst_i(cnt_rst), .psel_i(psel),
    .int_i(int_v), .frac_i(frac_v), .mod_i(mod_v), .fb_o(fb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fb(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fb && n < 3000);
    if (n >= 3000) begin
      fails++;
      $display("FAIL timeout waiting for pulse: actual %0d expected <3000", n);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, p, nmin, feff, m, base, lo, hi, len, sum, bad, seen;
    repeat (4) @(negedge clk);
    check("R1 fb low in reset", int'(fb), 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      cnt_rst = 1'b1;
      {int_v, frac_v, mod_v, psel} = VEC[v];
      @(negedge clk);
      @(negedge clk);
      cnt_rst = 1'b0;
      p    = psel ? 8 : 4;
      nmin = p * p - p;
      m    = int'(mod_v);
      feff = (m < 2) ? 0 : ((int'(frac_v) >= m) ? m - 1 : int'(frac_v));
      base = (int'(int_v) < nmin) ? nmin : int'(int_v);
      wait_fb(t);
      check($sformatf("R1 R9 first pulse v%0d", v), t, p);
      wait_fb(t);
      check($sformatf("R2 R10 R8 second interval v%0d", v), t, base);
      @(negedge clk);
      check($sformatf("R2 pulse width v%0d", v), int'(fb), 0);
      wait_fb(t); wait_fb(t); wait_fb(t);
      if (feff == 0) begin lo = base; hi = base; len = 12; end
      else begin lo = int'(int_v) - 3; hi = int'(int_v) + 4; len = 6 * m; end
      sum = 0; bad = 0;
      for (int k = 0; k < len; k++) begin
        wait_fb(t);
        sum += t;
        if (t < lo || t > hi) bad++;
      end
      check($sformatf("R5 R3 intervals out of range v%0d", v), bad, 0);
      if (feff == 0)
        check($sformatf("R3 R7 R8 window sum v%0d", v), sum, len * base);
      else
        check($sformatf("R4 R6 window sum v%0d", v), sum, 6 * (m * int'(int_v) + feff));
    end

    // counter reset held mid-run: no pulse, then clean restart
    @(negedge clk);
    {int_v, frac_v, mod_v, psel} = VEC[2];
    wait_fb(t);
    wait_fb(t);
    cnt_rst = 1'b1;
    @(negedge clk);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (fb) seen++;
    end
    check("R1 no pulse during counter reset", seen, 0);
    cnt_rst = 1'b0;
    wait_fb(t);
    check("R1 restart after counter reset", t, 4);
    wait_fb(t);
    check("R2 first interval after restart", t, 20);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule